// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block gives a chip a small, self-timed flash-style byte store that is driven like a classic asynchronous parallel flash, with the strobes sampled synchronously. A host reads it with chip enable and output enable low and write enable high. It changes the store only through fixed unlock write sequences. These sequences are a four-write byte program, a six-write sector erase and a six-write whole-array erase. Program can only clear bits. Erase returns bytes to FFh.

The store is split into sectors that are picked by the top bits of the address. Sector 0 is the boot sector. Sectors 1 and 2 are parameter sectors. Sectors 3 to 10 are main sectors. Each sector holds a parameterised number of bytes, and the low address bits pick the byte. When `boot_lock` is high, the boot sector cannot be changed by any command.

An internal down-counter times each operation. While it runs, a read inside the region under work returns the inverse of bit 7 of the byte being written, with the other bits zero. All write cycles are dropped until the counter expires.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the decoder is idle, every mapped byte reads FFh, and `rdata` is 00h in any cycle that was not a read cycle.
- R2: A read cycle (ce_n=0, oe_n=0, we_n=1) sampled at a clock edge puts the addressed byte on `rdata` at that edge.
- R3: A write cycle needs we_n=0, ce_n=0 and oe_n=1. The address is taken at the first edge of the cycle and the data at the edge where the cycle ends. A cycle with oe_n low is not a write.
- R4: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h and then target/data program the target byte to old AND data. Only the low 15 address bits are compared for command addresses.
- R5: The writes AAh, 55h, 80h at 5555h/2AAAh/5555h, then AAh/55h again, then data 30h set every byte of one sector to FFh. The sector is taken from the address present at the end of the sixth write. Other sectors are unchanged.
- R6: The same five writes followed by 10h at 5555h set every mapped byte to FFh when `boot_lock` is low.
- R7: With `boot_lock` high, program and sector erase aimed at sector 0 are dropped, and whole-array erase leaves sector 0 unchanged.
- R8: Any write that does not match the expected step returns the decoder to idle, and nothing is changed.
- R9: During an operation, a read inside the target region returns {~bit7, 7'b0}. The target region is the one byte for program, the sector for sector erase, and every erased sector for whole-array erase. The intended byte is FFh for erases. Reads outside the region return stored data. Operations last PROG_CYC or ERASE_CYC clocks.
- R10: Every write cycle issued while an operation runs is ignored.
- R11: The sector is addr[AW-1 -: 4]. Sectors 11 to 15 are unmapped: they read FFh, and program or erase aimed at them is dropped without starting an operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| we_n | input | 1 | Write strobe, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| boot_lock | input | 1 | Protects sector 0 when high |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data or status |

## Verification
The hardest case to reach from the ports is a write sequence that arrives while an operation is still timing out. It only shows up as a byte that should have changed but did not. The bench starts a long sector erase and at once sends a full program sequence to another sector. After the erase time has passed, it reads that byte back as FFh. A second hard case is telling apart the address taken at the start of a write from the one taken at its end. For this the bench moves the address in the middle of a held strobe, during both a program and a sector erase.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   localparam int CMD_AW = 15;
   localparam logic [CMD_AW-1:0] UNLOCK_A = 15'h5555;
   localparam logic [CMD_AW-1:0] UNLOCK_B = 15'h2AAA;
   localparam logic [7:0] KEY_A    = 8'hAA;
   localparam logic [7:0] KEY_B    = 8'h55;
   localparam logic [7:0] SEL_PROG = 8'hA0;
   localparam logic [7:0] SEL_ERS  = 8'h80;
   localparam logic [7:0] GO_CHIP  = 8'h10;
   localparam logic [7:0] GO_SECT  = 8'h30;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ERS1, SQ_ERS2, SQ_ERS3
   } seq_st_t;

   typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_t;
endpackage

// File: rtl/flash_bus_cap.sv
module flash_bus_cap #(
   parameter int AW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic          wr_evt,
   output logic [AW-1:0] cmd_addr,
   output logic [AW-1:0] end_addr,
   output logic [7:0]    cmd_data,
   output logic          rd_req
);
   logic          wr_act, wr_act_q;
   logic [AW-1:0] addr_l;

   assign wr_act = !we_n && !ce_n && oe_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         addr_l   <= '0;
      end else begin
         wr_act_q <= wr_act;
         if (wr_act && !wr_act_q) addr_l <= addr;
      end
   end

   assign wr_evt   = wr_act_q && !wr_act;
   assign cmd_addr = addr_l;
   assign end_addr = addr;
   assign cmd_data = wdata;
   assign rd_req   = !ce_n && !oe_n && we_n;

   a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_act && wr_act_q) |=> $stable(addr_l));
endmodule

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
   import flash_seq_pkg::*;
#(
   parameter int AW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_evt,
   input  logic [AW-1:0] cmd_addr,
   input  logic [AW-1:0] end_addr,
   input  logic [7:0]    cmd_data,
   input  logic          busy,
   output logic          op_go,
   output op_t           op_kind,
   output logic [AW-1:0] op_addr,
   output logic [7:0]    op_data
);
   seq_st_t st, st_n;
   logic [CMD_AW-1:0] ca;
   logic at_a, key_a, key_b;

   assign ca    = cmd_addr[CMD_AW-1:0];
   assign at_a  = (ca == UNLOCK_A);
   assign key_a = at_a && (cmd_data == KEY_A);
   assign key_b = (ca == UNLOCK_B) && (cmd_data == KEY_B);

   always_comb begin
      st_n    = st;
      op_go   = 1'b0;
      op_kind = OP_NONE;
      op_addr = cmd_addr;
      op_data = cmd_data;
      if (busy) begin
         st_n = SQ_IDLE;
      end else if (wr_evt) begin
         case (st)
            SQ_IDLE: st_n = key_a ? SQ_UNL1 : SQ_IDLE;
            SQ_UNL1: st_n = key_b ? SQ_UNL2 : SQ_IDLE;
            SQ_UNL2: begin
               if (at_a && cmd_data == SEL_PROG)     st_n = SQ_PROG;
               else if (at_a && cmd_data == SEL_ERS) st_n = SQ_ERS1;
               else                                  st_n = SQ_IDLE;
            end
            SQ_PROG: begin
               op_go   = 1'b1;
               op_kind = OP_PROG;
               st_n    = SQ_IDLE;
            end
            SQ_ERS1: st_n = key_a ? SQ_ERS2 : SQ_IDLE;
            SQ_ERS2: st_n = key_b ? SQ_ERS3 : SQ_IDLE;
            SQ_ERS3: begin
               st_n = SQ_IDLE;
               if (at_a && cmd_data == GO_CHIP) begin
                  op_go   = 1'b1;
                  op_kind = OP_CHIP;
               end else if (cmd_data == GO_SECT) begin
                  op_go   = 1'b1;
                  op_kind = OP_SECT;
                  op_addr = end_addr;
               end
            end
            default: st_n = SQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= SQ_IDLE;
      else        st <= st_n;
   end

   // R8: a finished sequence always leaves the decoder idle
   a_r8_idle_after_op: assert property (@(posedge clk) disable iff (!rst_n)
      op_go |=> (st == SQ_IDLE));
endmodule

// File: rtl/flash_store.sv
module flash_store
   import flash_seq_pkg::*;
#(
   parameter int AW        = 15,
   parameter int OFF_W     = 4,
   parameter int N_PARAM   = 2,
   parameter int N_MAIN    = 8,
   parameter int PROG_CYC  = 12,
   parameter int ERASE_CYC = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          boot_lock,
   input  logic          op_go,
   input  op_t           op_kind,
   input  logic [AW-1:0] op_addr,
   input  logic [7:0]    op_data,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   output logic          busy,
   output logic [7:0]    rdata
);
   localparam int NSECT = 1 + N_PARAM + N_MAIN;
   localparam int SW    = $clog2(NSECT);
   localparam int NSLOT = 2 ** SW;
   localparam int SB    = 2 ** OFF_W;
   localparam int IDX_W = SW + OFF_W;
   localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CW    = $clog2(MAXC + 1);

   logic [7:0]       mem [NSLOT*SB];
   logic [CW-1:0]    cnt;
   op_t              t_kind;
   logic [SW-1:0]    t_sect;
   logic [IDX_W-1:0] t_idx;
   logic [7:0]       t_data;
   logic             t_lock;
   logic [NSLOT-1:0] clr;

   logic [SW-1:0]    o_sect, r_sect;
   logic [IDX_W-1:0] o_idx, r_idx;
   logic             o_valid, r_valid, accept, r_hit, poll7;
   logic [7:0]       rd_val;

   assign o_sect  = op_addr[AW-1 -: SW];
   assign r_sect  = rd_addr[AW-1 -: SW];
   assign o_idx   = {o_sect, op_addr[OFF_W-1:0]};
   assign r_idx   = {r_sect, rd_addr[OFF_W-1:0]};
   assign o_valid = (int'(o_sect) < NSECT);
   assign r_valid = (int'(r_sect) < NSECT);
   assign busy    = (cnt != '0);
   assign accept  = op_go && !busy &&
                    ((op_kind == OP_CHIP) ||
                     (o_valid && !(boot_lock && o_sect == '0)));

   generate
      if (AW > SW + OFF_W) begin : g_mid
         logic unused_mid;
         assign unused_mid = ^{op_addr[AW-SW-1:OFF_W], rd_addr[AW-SW-1:OFF_W]};
      end
      for (genvar s = 0; s < NSLOT; s++) begin : g_sect
         if (s < NSECT) begin : g_map
            assign clr[s] = ((t_kind == OP_CHIP) && !(t_lock && s == 0)) ||
                            ((t_kind == OP_SECT) && (int'(t_sect) == s));
         end else begin : g_unmap
            assign clr[s] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         t_kind <= OP_NONE;
         t_sect <= '0;
         t_idx  <= '0;
         t_data <= '0;
         t_lock <= 1'b0;
         for (int i = 0; i < NSLOT*SB; i++) mem[i] <= 8'hFF;
      end else if (accept) begin
         cnt    <= (op_kind == OP_PROG) ? CW'(PROG_CYC) : CW'(ERASE_CYC);
         t_kind <= op_kind;
         t_sect <= o_sect;
         t_idx  <= o_idx;
         t_data <= op_data;
         t_lock <= boot_lock;
      end else if (busy) begin
         cnt <= cnt - 1'b1;
         if (cnt == CW'(1)) begin
            if (t_kind == OP_PROG) begin
               mem[t_idx] <= mem[t_idx] & t_data;
            end else begin
               for (int s = 0; s < NSLOT; s++)
                  for (int o = 0; o < SB; o++)
                     if (clr[s]) mem[s*SB + o] <= 8'hFF;
            end
         end
      end
   end

   assign poll7 = (t_kind == OP_PROG) ? t_data[7] : 1'b1;
   assign r_hit = (t_kind == OP_PROG) ? (r_idx == t_idx) : clr[r_sect];

   always_comb begin
      if (!r_valid)            rd_val = 8'hFF;
      else if (busy && r_hit)  rd_val = {~poll7, 7'h00};
      else                     rd_val = mem[r_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= 8'h00;
      else        rdata <= rd_req ? rd_val : 8'h00;
   end

   a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) <= MAXC);
   a_r10_no_op_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !op_go);
   a_r4_prog_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(1) && t_kind == OP_PROG) |=>
         ((mem[t_idx] & ~$past(mem[t_idx])) == 8'h00));
   a_r7_boot_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(1) && t_kind == OP_CHIP && t_lock) |=> (mem[0] == $past(mem[0])));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import flash_seq_pkg::*;
#(
   parameter int AW        = 15,
   parameter int OFF_W     = 4,
   parameter int N_PARAM   = 2,
   parameter int N_MAIN    = 8,
   parameter int PROG_CYC  = 12,
   parameter int ERASE_CYC = 40
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_n,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic          boot_lock,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   localparam int SW = $clog2(1 + N_PARAM + N_MAIN);

   generate
      if (AW < CMD_AW) begin : g_chk_aw
         $error("address bus narrower than command addresses");
      end
      if (AW < SW + OFF_W) begin : g_chk_split
         $error("sector and offset fields overlap");
      end
      if (OFF_W < 1 || PROG_CYC < 1 || ERASE_CYC < 1) begin : g_chk_min
         $error("offset width and busy times must be at least 1");
      end
   endgenerate

   logic          wr_evt, rd_req, busy, op_go;
   logic [AW-1:0] cmd_addr, end_addr, op_addr;
   logic [7:0]    cmd_data, op_data;
   op_t           op_kind;

   flash_bus_cap #(.AW(AW)) i_bus (
      .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
      .addr(addr), .wdata(wdata), .wr_evt(wr_evt), .cmd_addr(cmd_addr),
      .end_addr(end_addr), .cmd_data(cmd_data), .rd_req(rd_req)
   );

   flash_cmd_dec #(.AW(AW)) i_dec (
      .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .cmd_addr(cmd_addr),
      .end_addr(end_addr), .cmd_data(cmd_data), .busy(busy),
      .op_go(op_go), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
   );

   flash_store #(
      .AW(AW), .OFF_W(OFF_W), .N_PARAM(N_PARAM), .N_MAIN(N_MAIN),
      .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .boot_lock(boot_lock), .op_go(op_go),
      .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
      .rd_req(rd_req), .rd_addr(addr), .busy(busy), .rdata(rdata)
   );
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
   localparam int AW = 15, PROG = 12, ERS = 40;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, we_n, ce_n, oe_n, boot_lock;
   logic [AW-1:0] addr;
   logic [7:0]    wdata, rdata;
   int            errors = 0, checks = 0;
   bit            done = 0;
   logic [7:0]    exp_q[$];
   string         tag_q[$];
   event          rd_ev;

   flash_cmd_seq #(.AW(AW), .PROG_CYC(PROG), .ERASE_CYC(ERS)) i_flash_cmd_seq (
      .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
      .boot_lock(boot_lock), .addr(addr), .wdata(wdata), .rdata(rdata)
   );

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected byte for every completed read
   initial forever begin
      @(rd_ev);
      chk(tag_q.pop_front(), rdata, exp_q.pop_front());
   end

   task automatic wr(logic [AW-1:0] a, logic [7:0] d, logic oe_v = 1'b1);
      @(negedge clk); addr = a; wdata = d; oe_n = oe_v; ce_n = 0; we_n = 0;
      @(negedge clk); we_n = 1; ce_n = 1; oe_n = 1;
      @(negedge clk);
   endtask

   task automatic wr_mv(logic [AW-1:0] a1, logic [AW-1:0] a2, logic [7:0] d);
      @(negedge clk); addr = a1; wdata = d; ce_n = 0; we_n = 0;
      @(negedge clk); addr = a2;
      @(negedge clk); we_n = 1; ce_n = 1;
      @(negedge clk);
   endtask

   task automatic rd(logic [AW-1:0] a, logic [7:0] exp, string tag);
      @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk); -> rd_ev; ce_n = 1; oe_n = 1;
   endtask

   task automatic unlock3(logic [7:0] sel);
      wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, sel);
   endtask
   task automatic prog(logic [AW-1:0] a, logic [7:0] d);
      unlock3(8'hA0); wr(a, d);
   endtask
   task automatic ers5();
      unlock3(8'h80); wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
   endtask
   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      rst_n = 0; we_n = 1; ce_n = 1; oe_n = 1; boot_lock = 0; addr = '0; wdata = '0;
      wait_n(3); rst_n = 1;
      @(negedge clk); chk("R1 idle output", rdata, 8'h00);
      rd(15'h0000, 8'hFF, "R1 boot erased at reset");
      rd(15'h2805, 8'hFF, "R1 main erased at reset");

      prog(15'h1802, 8'hA5);
      rd(15'h1802, 8'h00, "R9 poll of A5");
      rd(15'h1803, 8'hFF, "R9 other byte while busy");
      wait_n(PROG + 4);
      rd(15'h1802, 8'hA5, "R4 program");
      prog(15'h1803, 8'h5A);
      rd(15'h1803, 8'h80, "R9 poll of 5A");
      wait_n(PROG + 4);
      rd(15'h1803, 8'h5A, "R2 stored byte read back");
      prog(15'h1802, 8'h0F); wait_n(PROG + 4);
      rd(15'h1802, 8'h05, "R4 old AND new");

      wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h56); wr(15'h5555, 8'hA0); wr(15'h1805, 8'h00);
      wait_n(PROG + 4);
      rd(15'h1805, 8'hFF, "R8 mismatch drops sequence");
      prog(15'h1805, 8'h3C); wait_n(PROG + 4);
      rd(15'h1805, 8'h3C, "R8 decoder back to idle");

      wr(15'h5555, 8'hAA, 1'b0); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0); wr(15'h1806, 8'h00);
      wait_n(PROG + 4);
      rd(15'h1806, 8'hFF, "R3 oe low blocks write");
      unlock3(8'hA0); wr_mv(15'h1806, 15'h1807, 8'hC3); wait_n(PROG + 4);
      rd(15'h1806, 8'hC3, "R3 address from start of write");
      rd(15'h1807, 8'hFF, "R3 end address not used for program");

      prog(15'h2000, 8'h11); wait_n(PROG + 4);
      ers5(); wr_mv(15'h2000, 15'h1800, 8'h30);
      rd(15'h1801, 8'h00, "R9 poll in sector erase");
      rd(15'h2000, 8'h11, "R9 outside erased sector");
      wait_n(ERS + 4);
      rd(15'h1802, 8'hFF, "R5 sector cleared");
      rd(15'h1805, 8'hFF, "R5 sector cleared 2");
      rd(15'h2000, 8'h11, "R5 other sector kept");

      ers5(); wr(15'h2000, 8'h30);
      prog(15'h2800, 8'h00);
      wait_n(ERS + 4);
      rd(15'h2800, 8'hFF, "R10 program during erase ignored");
      rd(15'h2000, 8'hFF, "R5 sector 4 erased");

      prog(15'h0000, 8'h3C); wait_n(PROG + 4);
      prog(15'h0800, 8'h00); wait_n(PROG + 4);
      prog(15'h5000, 8'h00); wait_n(PROG + 4);
      rd(15'h0000, 8'h3C, "R11 boot programmable when unlocked");
      ers5(); wr(15'h5555, 8'h10);
      rd(15'h0800, 8'h00, "R9 poll in chip erase");
      wait_n(ERS + 4);
      rd(15'h0000, 8'hFF, "R6 boot cleared");
      rd(15'h0800, 8'hFF, "R6 param cleared");
      rd(15'h5000, 8'hFF, "R6 last main cleared");

      prog(15'h0001, 8'h12); wait_n(PROG + 4);
      boot_lock = 1;
      prog(15'h0002, 8'h00); wait_n(PROG + 4);
      rd(15'h0002, 8'hFF, "R7 locked boot program dropped");
      ers5(); wr(15'h0000, 8'h30); wait_n(ERS + 4);
      rd(15'h0001, 8'h12, "R7 locked boot sector erase dropped");
      prog(15'h0801, 8'h00); wait_n(PROG + 4);
      ers5(); wr(15'h5555, 8'h10);
      rd(15'h0001, 8'h12, "R7 boot outside locked chip erase");
      wait_n(ERS + 4);
      rd(15'h0801, 8'hFF, "R7 param cleared under lock");
      rd(15'h0001, 8'h12, "R7 boot kept under lock");
      boot_lock = 0;

      rd(15'h6000, 8'hFF, "R11 unmapped read");
      prog(15'h5803, 8'h00);
      prog(15'h1808, 8'h00); wait_n(PROG + 4);
      rd(15'h1808, 8'h00, "R11 unmapped program starts no operation");
      rd(15'h5803, 8'hFF, "R11 unmapped stays FF");

      wait_n(3);
      chk("R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL R1 watchdog: actual=timeout expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule